// File: doc/BRIEF.md
# Double-Buffered Frame Base Registers

This register unit sits inside a display controller. It holds the starting memory address of the frame data for two panels, an upper panel and a lower panel, for dual-panel screens. Software writes these addresses over a single-cycle register bus. The display DMA never reads them directly. It reads a second, "current" copy of each address, and that copy changes only on a vertical synchronization boundary. A frame that is being fetched therefore never sees a half-updated address.

Each copy on a vsync pulse sets a status flag. The flag tells software that both programmed addresses may now be rewritten for the next frame. When an enable bit is set, the flag also drives an interrupt line, so double-buffered video can swap buffers once per frame. While the controller is disabled, the current copies follow the programmed values. The first frame after enable therefore uses the addresses that software set up beforehand.

Top module: `fb_base_shadow`

## Requirements
- R1: Offset 0x10 holds the upper-panel programmed base and offset 0x14 holds the lower-panel programmed base. Both are written with `wr_en` and read back on `rd_data` in the same cycle that `rd_addr` selects them.
- R2: Address bits 1:0 are never stored. A write sets them to 0 in the register, and both reads and the current outputs show them as 0.
- R3: After a synchronous reset, every base register, current output, the status flag, the interrupt enable and `irq` are 0.
- R4: While `ctrl_en` is 1, a current output loads its programmed value at the clock edge where `vsync` is 1 and holds its value at every other edge.
- R5: A clock edge with both `vsync` and `ctrl_en` at 1 sets the status flag. The flag appears on `swap_ready` and in bit 0 of a read at offset 0x1C.
- R6: `irq` equals the status flag AND the interrupt enable. The enable is bit 0 of offset 0x18, which is writable and readable. `irq` changes at the same edge as the flag.
- R7: A write to offset 0x20 with bit 0 set clears the status flag. A write there with bit 0 clear has no effect, and a read of 0x20 returns 0.
- R8: If a base write and a vsync copy fall on the same edge, the current output takes the value that was programmed before the write. The new value is copied at the next vsync.
- R9: If a clear write and a vsync copy fall on the same edge, the status flag ends up set.
- R10: While `ctrl_en` is 0, each current output takes its programmed value at every edge, so it lags the programmed value by one cycle, and vsync does not set the status flag.
- R11: A write to any other offset changes no state, and a read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | OFF_W | Write byte offset |
| wr_data | input | DW | Write data |
| rd_addr | input | OFF_W | Read byte offset |
| rd_data | output | DW | Combinational read data |
| vsync | input | 1 | One-cycle vertical sync pulse |
| ctrl_en | input | 1 | Controller enable |
| upper_cur | output | DW | Current upper-panel base for the DMA |
| lower_cur | output | DW | Current lower-panel base for the DMA |
| swap_ready | output | 1 | Safe-to-update status flag |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a register write to a base address together with the vsync copy. The second pair is the software clear of the status flag together with the vsync set. The bench drives `wr_en` and `vsync` in the same cycle for both pairs. For the first pair it judges the current output against the value programmed before the write, and then checks again after the following vsync. For the second pair it expects the flag and `irq` to stay set.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  // register byte offsets
  localparam int OFS_UPPER  = 'h10;
  localparam int OFS_LOWER  = 'h14;
  localparam int OFS_IEN    = 'h18;
  localparam int OFS_STATUS = 'h1C;
  localparam int OFS_CLEAR  = 'h20;
  localparam int NUM_PANELS = 2;

  typedef enum logic [0:0] {
    PANEL_UPPER = 1'b0,
    PANEL_LOWER = 1'b1
  } panel_e;
endpackage

// File: rtl/fbs_base_pair.sv
module fbs_base_pair #(
  parameter int DW = 32,
  parameter int AL = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_hit,
  input  logic [DW-1:0] wr_data,
  input  logic          ctrl_en,
  input  logic          vsync,
  output logic [DW-1:0] prog_q,
  output logic [DW-1:0] cur_q
);
  localparam logic [AL-1:0] ZERO_LO = '0;

  logic copy;
  assign copy = vsync || !ctrl_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_q <= '0;
      cur_q  <= '0;
    end else begin
      if (wr_hit) prog_q <= {wr_data[DW-1:AL], ZERO_LO};
      // copy uses the value before any same-cycle write
      if (copy) cur_q <= prog_q;
    end
  end
endmodule

// File: rtl/fbs_status.sv
module fbs_status (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr_evt,
  input  logic ien_we,
  input  logic ien_d,
  output logic status_q,
  output logic ien_q,
  output logic irq_q
);
  logic status_nx, ien_nx;

  // a set on the same edge as a clear wins
  assign status_nx = set_evt || (status_q && !clr_evt);
  assign ien_nx    = ien_we ? ien_d : ien_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= 1'b0;
      ien_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_nx;
      ien_q    <= ien_nx;
      irq_q    <= status_nx && ien_nx;
    end
  end
endmodule

// File: rtl/fbs_readmux.sv
module fbs_readmux #(
  parameter int DW    = 32,
  parameter int OFF_W = 8
) (
  input  logic [OFF_W-1:0] rd_addr,
  input  logic [DW-1:0]    upper_prog,
  input  logic [DW-1:0]    lower_prog,
  input  logic             ien,
  input  logic             status,
  output logic [DW-1:0]    rd_data
);
  import fbs_pkg::*;

  always_comb begin
    rd_data = '0;
    if (rd_addr == OFF_W'(OFS_UPPER))       rd_data = upper_prog;
    else if (rd_addr == OFF_W'(OFS_LOWER))  rd_data = lower_prog;
    else if (rd_addr == OFF_W'(OFS_IEN))    rd_data[0] = ien;
    else if (rd_addr == OFF_W'(OFS_STATUS)) rd_data[0] = status;
  end
endmodule

// File: rtl/fb_base_shadow.sv
module fb_base_shadow #(
  parameter int DW    = 32,
  parameter int OFF_W = 8,
  parameter int AL    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [OFF_W-1:0] rd_addr,
  output logic [DW-1:0]    rd_data,
  input  logic             vsync,
  input  logic             ctrl_en,
  output logic [DW-1:0]    upper_cur,
  output logic [DW-1:0]    lower_cur,
  output logic             swap_ready,
  output logic             irq
);
  import fbs_pkg::*;

  logic [DW-1:0] prog [NUM_PANELS];
  logic [DW-1:0] cur  [NUM_PANELS];
  logic          ien_q;

  for (genvar p = 0; p < NUM_PANELS; p++) begin : g_panel
    localparam int PANEL_OFS = (p == int'(PANEL_UPPER)) ? OFS_UPPER : OFS_LOWER;
    logic hit;
    assign hit = wr_en && (wr_addr == OFF_W'(PANEL_OFS));
    fbs_base_pair #(.DW(DW), .AL(AL)) u_pair (
      .clk(clk), .rst(rst), .wr_hit(hit), .wr_data(wr_data),
      .ctrl_en(ctrl_en), .vsync(vsync), .prog_q(prog[p]), .cur_q(cur[p])
    );
  end

  assign upper_cur = cur[PANEL_UPPER];
  assign lower_cur = cur[PANEL_LOWER];

  logic set_evt, clr_evt, ien_we;
  assign set_evt = vsync && ctrl_en;
  assign clr_evt = wr_en && (wr_addr == OFF_W'(OFS_CLEAR)) && wr_data[0];
  assign ien_we  = wr_en && (wr_addr == OFF_W'(OFS_IEN));

  fbs_status u_status (
    .clk(clk), .rst(rst), .set_evt(set_evt), .clr_evt(clr_evt),
    .ien_we(ien_we), .ien_d(wr_data[0]),
    .status_q(swap_ready), .ien_q(ien_q), .irq_q(irq)
  );

  fbs_readmux #(.DW(DW), .OFF_W(OFF_W)) u_rd (
    .rd_addr(rd_addr), .upper_prog(prog[PANEL_UPPER]), .lower_prog(prog[PANEL_LOWER]),
    .ien(ien_q), .status(swap_ready), .rd_data(rd_data)
  );
endmodule

// File: rtl/fbs_chk.sv
module fbs_chk #(
  parameter int DW    = 32,
  parameter int OFF_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [OFF_W-1:0] wr_addr,
  input logic [DW-1:0]    wr_data,
  input logic             vsync,
  input logic             ctrl_en,
  input logic [DW-1:0]    upper_cur,
  input logic [DW-1:0]    lower_cur,
  input logic [DW-1:0]    upper_prog,
  input logic             swap_ready,
  input logic             ien,
  input logic             irq
);
  // R2
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    upper_cur[1:0] == 2'b00 && lower_cur[1:0] == 2'b00);

  // R4
  cur_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_en && !vsync) |=> ($stable(upper_cur) && $stable(lower_cur)));

  // R8
  copy_old_value_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_en && vsync) |=> (upper_cur == $past(upper_prog)));

  // R5
  status_set_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_en && vsync) |=> swap_ready);

  // R6
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (swap_ready && ien));

  // R7
  status_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == OFF_W'('h20) && wr_data[0] && !(vsync && ctrl_en)) |=> !swap_ready);
endmodule

bind fb_base_shadow fbs_chk #(.DW(DW), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .vsync(vsync), .ctrl_en(ctrl_en), .upper_cur(upper_cur), .lower_cur(lower_cur),
  .upper_prog(prog[0]), .swap_ready(swap_ready), .ien(ien_q), .irq(irq)
);

// File: tb/fb_base_shadow_bench.sv
`timescale 1ns/1ps
module fb_base_shadow_bench;
  localparam int DW = 32;
  localparam int OFF_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [OFF_W-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [OFF_W-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic vsync = 1'b0;
  logic ctrl_en = 1'b0;
  logic [DW-1:0] upper_cur, lower_cur;
  logic swap_ready, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fb_base_shadow #(.DW(DW), .OFF_W(OFF_W)) u_fb_base_shadow (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .vsync(vsync), .ctrl_en(ctrl_en),
    .upper_cur(upper_cur), .lower_cur(lower_cur), .swap_ready(swap_ready), .irq(irq)
  );

  typedef struct packed {
    logic        we;
    logic [7:0]  a;
    logic [31:0] d;
    logic        vs;
    logic        en;
    logic [31:0] eu;
    logic [31:0] el;
    logic        es;
    logic        ei;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h10, 32'h1000_0003, 1'b0, 1'b0, 32'h0,         32'h0,         1'b0, 1'b0}, // R10 lag
    '{1'b1, 8'h14, 32'h2000_0007, 1'b0, 1'b0, 32'h1000_0000, 32'h0,         1'b0, 1'b0}, // R2 R10
    '{1'b0, 8'h00, 32'h0,         1'b0, 1'b0, 32'h1000_0000, 32'h2000_0004, 1'b0, 1'b0},
    '{1'b1, 8'h18, 32'h1,         1'b0, 1'b1, 32'h1000_0000, 32'h2000_0004, 1'b0, 1'b0}, // R6 enable
    '{1'b1, 8'h10, 32'h3000_0000, 1'b0, 1'b1, 32'h1000_0000, 32'h2000_0004, 1'b0, 1'b0}, // R4 hold
    '{1'b0, 8'h00, 32'h0,         1'b1, 1'b1, 32'h3000_0000, 32'h2000_0004, 1'b1, 1'b1}, // R4 R5 copy
    '{1'b1, 8'h20, 32'h1,         1'b0, 1'b1, 32'h3000_0000, 32'h2000_0004, 1'b0, 1'b0}, // R7 clear
    '{1'b1, 8'h10, 32'h4000_0000, 1'b1, 1'b1, 32'h3000_0000, 32'h2000_0004, 1'b1, 1'b1}, // R8 collision
    '{1'b0, 8'h00, 32'h0,         1'b1, 1'b1, 32'h4000_0000, 32'h2000_0004, 1'b1, 1'b1}, // R8 next vsync
    '{1'b1, 8'h20, 32'h1,         1'b1, 1'b1, 32'h4000_0000, 32'h2000_0004, 1'b1, 1'b1}, // R9 set wins
    '{1'b1, 8'h18, 32'h0,         1'b0, 1'b1, 32'h4000_0000, 32'h2000_0004, 1'b1, 1'b0}, // R6 masked
    '{1'b1, 8'h20, 32'h0,         1'b0, 1'b1, 32'h4000_0000, 32'h2000_0004, 1'b1, 1'b0}, // R7 bit0 clear
    '{1'b1, 8'h20, 32'h1,         1'b0, 1'b1, 32'h4000_0000, 32'h2000_0004, 1'b0, 1'b0}, // R7
    '{1'b1, 8'h14, 32'h5000_0000, 1'b0, 1'b1, 32'h4000_0000, 32'h2000_0004, 1'b0, 1'b0}, // R4 hold
    '{1'b0, 8'h00, 32'h0,         1'b1, 1'b0, 32'h4000_0000, 32'h5000_0000, 1'b0, 1'b0}, // R10 no set
    '{1'b1, 8'h24, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h4000_0000, 32'h5000_0000, 1'b0, 1'b0}  // R11
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_chk(input string req, input logic [7:0] a, input logic [DW-1:0] exp);
    rd_addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d,
                      input logic vs, input logic en);
    wr_en = we; wr_addr = a; wr_data = d; vsync = vs; ctrl_en = en;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; vsync = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R3 reset state
    check("R3 upper_cur", upper_cur, '0);
    check("R3 lower_cur", lower_cur, '0);
    check("R3 status", {31'b0, swap_ready}, '0);
    check("R3 irq", {31'b0, irq}, '0);
    read_chk("R3 read upper", 8'h10, '0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].we, VEC[i].a, VEC[i].d, VEC[i].vs, VEC[i].en);
      check($sformatf("R4 upper_cur v%0d", i), upper_cur, VEC[i].eu);
      check($sformatf("R4 lower_cur v%0d", i), lower_cur, VEC[i].el);
      check($sformatf("R5 status v%0d", i), {31'b0, swap_ready}, {31'b0, VEC[i].es});
      check($sformatf("R6 irq v%0d", i), {31'b0, irq}, {31'b0, VEC[i].ei});
    end

    // R1 R11 readback
    read_chk("R1 read upper", 8'h10, 32'h4000_0000);
    read_chk("R1 read lower", 8'h14, 32'h5000_0000);
    read_chk("R6 read ien", 8'h18, 32'h0);
    read_chk("R5 read status", 8'h1C, 32'h0);
    read_chk("R7 read clear", 8'h20, 32'h0);
    read_chk("R11 read unmapped", 8'h24, 32'h0);

    // R2 low bits dropped on write
    step(1'b1, 8'h10, 32'hFFFF_FFFF, 1'b0, 1'b1);
    read_chk("R2 read masked", 8'h10, 32'hFFFF_FFFC);
    step(1'b0, 8'h00, 32'h0, 1'b1, 1'b1);
    check("R2 cur masked", upper_cur, 32'hFFFF_FFFC);
    read_chk("R5 read status set", 8'h1C, 32'h1);

    // R3 mid-run reset
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R3 upper_cur after reset", upper_cur, '0);
    check("R3 status after reset", {31'b0, swap_ready}, '0);
    read_chk("R3 read upper after reset", 8'h10, '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule